// File: doc/BRIEF.md
# Interruption State Capture Unit

This unit sits next to a core that issues instructions in three-slot bundles. When the core takes an interruption, the unit freezes the machine context into a bank of eight saved registers. It stores the live status word, with the slot that did not finish written into it, and the address of the bundle that did not complete. Depending on the class of the interruption, it also stores the faulting address and its page attributes, the page-table hash address, or the immediate field of the trapping instruction. It clears the valid flag of the saved frame-state word. While the collection bit of the live status word is set, it also records the address of every bundle that retires.

A return-from-interruption strobe makes the unit present the saved status word for reload, and the saved instruction pointer as the fetch redirect target, on the following cycle. A handler can use the software write port to change the saved context beforehand, for example to resume past an emulated instruction. A combinational read port shows any saved register.

Top module: `intr_state_capture`

## Requirements
- R1: On an interruption, the saved status register (read select 0) takes the live status word, except bits [SLOT_LSB+1:SLOT_LSB] (default 9:8), which take the 2-bit slot index.
- R2: On an interruption, the saved instruction pointer (select 1) takes the bundle address with bits [3:0] forced to zero. Those bits read zero at all times.
- R3: An rfi strobe without an interruption raises restoreValid in the next cycle, with restoredStatus equal to the saved status and redirAddr equal to the saved pointer as they stood in the rfi cycle. Both outputs hold their value until the next restore.
- R4: The last-retired register (select 4) takes the retire address with bits [3:0] zeroed, but only when retireValid is high and live status bit IC_BIT (default 13) is 1.
- R5: Interruption class codes 1 (address fault) and 2 (table-walk fault) load the fault-address register (select 2) and the page-attribute register (select 3). All other codes leave both unchanged.
- R6: Class codes 3 (break) and 4 (speculation check) load the immediate register (select 5) with the IMM_W-bit immediate, zero-extended.
- R7: Only class code 2 loads the hash-address register (select 6).
- R8: On an interruption, the frame-state register (select 7) has bit DATA_W-1 cleared, and its other bits are unchanged.
- R9: A software write loads the selected register, with bits [3:0] masked to zero for selects 1 and 4. A later rfi restores the written values.
- R10: If an interruption and an rfi arrive in the same cycle, the interruption is taken and no restore occurs.
- R11: If a hardware update and a software write target the same register in the same cycle, the hardware value wins.
- R12: After reset, every saved register, restoreValid, restoredStatus and redirAddr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| liveStatus | input | DATA_W | Current status word |
| bundleIp | input | DATA_W | Address of the interrupted bundle |
| slotIdx | input | 2 | Slot (0..2) of the interrupted instruction |
| retireValid | input | 1 | A bundle retired this cycle |
| retireAddr | input | DATA_W | Address of the retired bundle |
| intrReq | input | 1 | Interruption taken this cycle |
| intrClass | input | 4 | Interruption class code |
| faultAddr | input | DATA_W | Faulting data address |
| pageAttr | input | DATA_W | Page size and protection key of the region |
| hashAddr | input | DATA_W | Page-table hash address |
| intrImm | input | IMM_W | Immediate of the trapping instruction |
| rfiReq | input | 1 | Return-from-interruption strobe |
| swWrEn | input | 1 | Software write enable |
| swWrSel | input | 3 | Software write register select |
| swWrData | input | DATA_W | Software write data |
| rdSel | input | 3 | Read register select |
| rdData | output | DATA_W | Selected saved register |
| restoreValid | output | 1 | Restore and redirect valid this cycle |
| restoredStatus | output | DATA_W | Status word to reload |
| redirAddr | output | DATA_W | Fetch redirect address |

## Verification
A wrong captured value stays hidden until rfi or a read exposes it. The bench reads all eight registers after every clock, so a wrong capture shows up within one cycle of the edge that stored it, not at a later return. A wrong class decode shows up as the wrong register moving, or the right one staying put, in the cycle after the interruption. A priority error between interruption, rfi and software write shows up either as a restoreValid pulse where none belongs or as a software value that should have lost to a captured one.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int NUM_REGS = 8;

  localparam logic [3:0] CLS_ADDR  = 4'd1;
  localparam logic [3:0] CLS_WALK  = 4'd2;
  localparam logic [3:0] CLS_BREAK = 4'd3;
  localparam logic [3:0] CLS_SPEC  = 4'd4;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_IP     = 3'd1,
    SEL_FADDR  = 3'd2,
    SEL_ATTR   = 3'd3,
    SEL_LAST   = 3'd4,
    SEL_IMM    = 3'd5,
    SEL_HASH   = 3'd6,
    SEL_FRAME  = 3'd7
  } regSel_t;

  typedef struct packed {
    logic                capture;
    logic                ldAddr;
    logic                ldHash;
    logic                ldImm;
    logic                ldRetired;
    logic                restore;
    logic [NUM_REGS-1:0] swLoad;
  } strobe_t;
endpackage

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
(
  input  logic       intrReq,
  input  logic [3:0] intrClass,
  input  logic       rfiReq,
  input  logic       retireValid,
  input  logic       icBit,
  input  logic       swWrEn,
  input  logic [2:0] swWrSel,
  output strobe_t    strobes
);
  logic isAddrClass;
  logic isImmClass;

  assign isAddrClass = (intrClass == CLS_ADDR) || (intrClass == CLS_WALK);
  assign isImmClass  = (intrClass == CLS_BREAK) || (intrClass == CLS_SPEC);

  assign strobes.capture   = intrReq;
  assign strobes.ldAddr    = intrReq && isAddrClass;
  assign strobes.ldHash    = intrReq && (intrClass == CLS_WALK);
  assign strobes.ldImm     = intrReq && isImmClass;
  assign strobes.ldRetired = retireValid && icBit;
  // interruption has priority over a same-cycle return
  assign strobes.restore   = rfiReq && !intrReq;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_swdec
    assign strobes.swLoad[g] = swWrEn && (swWrSel == 3'(g));
  end
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 21,
  parameter int SLOT_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] liveStatus,
  input  logic [DATA_W-1:0] bundleIp,
  input  logic [1:0]        slotIdx,
  input  logic [DATA_W-1:0] retireAddr,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic [DATA_W-1:0] pageAttr,
  input  logic [DATA_W-1:0] hashAddr,
  input  logic [IMM_W-1:0]  intrImm,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [2:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              restoreValid,
  output logic [DATA_W-1:0] restoredStatus,
  output logic [DATA_W-1:0] redirAddr
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'(4'hF);
  localparam logic [DATA_W-1:0] VALID_MASK = ~(DATA_W'(1) << (DATA_W - 1));

  logic [DATA_W-1:0] savedStatus, savedIp, faultAddrQ, pageAttrQ;
  logic [DATA_W-1:0] lastRetired, immQ, hashQ, frameState;
  logic [DATA_W-1:0] statusCapture;

  always_comb begin
    statusCapture = liveStatus;
    statusCapture[SLOT_LSB +: 2] = slotIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedStatus <= '0;
      savedIp     <= '0;
    end else begin
      if (strobes.capture) begin
        savedStatus <= statusCapture;
        savedIp     <= bundleIp & ALIGN_MASK;
      end else begin
        if (strobes.swLoad[SEL_STATUS]) savedStatus <= swWrData;
        if (strobes.swLoad[SEL_IP])     savedIp     <= swWrData & ALIGN_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddrQ <= '0;
      pageAttrQ  <= '0;
    end else if (strobes.ldAddr) begin
      faultAddrQ <= faultAddr;
      pageAttrQ  <= pageAttr;
    end else begin
      if (strobes.swLoad[SEL_FADDR]) faultAddrQ <= swWrData;
      if (strobes.swLoad[SEL_ATTR])  pageAttrQ  <= swWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     lastRetired <= '0;
    else if (strobes.ldRetired)    lastRetired <= retireAddr & ALIGN_MASK;
    else if (strobes.swLoad[SEL_LAST]) lastRetired <= swWrData & ALIGN_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        immQ <= '0;
    else if (strobes.ldImm)           immQ <= DATA_W'(intrImm);
    else if (strobes.swLoad[SEL_IMM]) immQ <= swWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         hashQ <= '0;
    else if (strobes.ldHash)           hashQ <= hashAddr;
    else if (strobes.swLoad[SEL_HASH]) hashQ <= swWrData;
  end

  logic [DATA_W-1:0] frameNext;
  always_comb begin
    frameNext = strobes.swLoad[SEL_FRAME] ? swWrData : frameState;
    if (strobes.capture) frameNext = frameNext & VALID_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) frameState <= '0;
    else       frameState <= frameNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      restoreValid   <= 1'b0;
      restoredStatus <= '0;
      redirAddr      <= '0;
    end else begin
      restoreValid <= strobes.restore;
      if (strobes.restore) begin
        restoredStatus <= savedStatus;
        redirAddr      <= savedIp;
      end
    end
  end

  always_comb begin
    unique case (regSel_t'(rdSel))
      SEL_STATUS: rdData = savedStatus;
      SEL_IP:     rdData = savedIp;
      SEL_FADDR:  rdData = faultAddrQ;
      SEL_ATTR:   rdData = pageAttrQ;
      SEL_LAST:   rdData = lastRetired;
      SEL_IMM:    rdData = immQ;
      SEL_HASH:   rdData = hashQ;
      SEL_FRAME:  rdData = frameState;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/intr_state_capture.sv
module intr_state_capture
  import isc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int IMM_W    = 21,
  parameter int SLOT_LSB = 8,
  parameter int IC_BIT   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] liveStatus,
  input  logic [DATA_W-1:0] bundleIp,
  input  logic [1:0]        slotIdx,
  input  logic              retireValid,
  input  logic [DATA_W-1:0] retireAddr,
  input  logic              intrReq,
  input  logic [3:0]        intrClass,
  input  logic [DATA_W-1:0] faultAddr,
  input  logic [DATA_W-1:0] pageAttr,
  input  logic [DATA_W-1:0] hashAddr,
  input  logic [IMM_W-1:0]  intrImm,
  input  logic              rfiReq,
  input  logic              swWrEn,
  input  logic [2:0]        swWrSel,
  input  logic [DATA_W-1:0] swWrData,
  input  logic [2:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              restoreValid,
  output logic [DATA_W-1:0] restoredStatus,
  output logic [DATA_W-1:0] redirAddr
);
  strobe_t strobes;

  isc_ctrl u_ctrl (
    .intrReq    (intrReq),
    .intrClass  (intrClass),
    .rfiReq     (rfiReq),
    .retireValid(retireValid),
    .icBit      (liveStatus[IC_BIT]),
    .swWrEn     (swWrEn),
    .swWrSel    (swWrSel),
    .strobes    (strobes)
  );

  isc_datapath #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SLOT_LSB(SLOT_LSB)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .liveStatus    (liveStatus),
    .bundleIp      (bundleIp),
    .slotIdx       (slotIdx),
    .retireAddr    (retireAddr),
    .faultAddr     (faultAddr),
    .pageAttr      (pageAttr),
    .hashAddr      (hashAddr),
    .intrImm       (intrImm),
    .swWrData      (swWrData),
    .rdSel         (rdSel),
    .rdData        (rdData),
    .restoreValid  (restoreValid),
    .restoredStatus(restoredStatus),
    .redirAddr     (redirAddr)
  );
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int DATA_W   = 64,
  parameter int SLOT_LSB = 8,
  parameter int IC_BIT   = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              intrReq,
  input logic              rfiReq,
  input logic [1:0]        slotIdx,
  input logic [DATA_W-1:0] liveStatus,
  input logic              retireValid,
  input logic              swWrEn,
  input logic              restoreValid,
  input logic [DATA_W-1:0] restoredStatus,
  input logic [DATA_W-1:0] redirAddr,
  input logic [DATA_W-1:0] savedStatus,
  input logic [DATA_W-1:0] savedIp,
  input logic [DATA_W-1:0] lastRetired,
  input logic [DATA_W-1:0] frameState
);
  p_slot_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    intrReq |=> savedStatus[SLOT_LSB +: 2] == $past(slotIdx));

  p_ip_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    savedIp[3:0] == 4'h0 && redirAddr[3:0] == 4'h0);

  p_rfi_restore_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rfiReq && !intrReq) |=> restoreValid && redirAddr == $past(savedIp)
                             && restoredStatus == $past(savedStatus));

  p_retire_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!(retireValid && liveStatus[IC_BIT]) && !swWrEn) |=> $stable(lastRetired));

  p_frame_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    intrReq |=> !frameState[DATA_W-1]);

  p_intr_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intrReq && rfiReq) |=> !restoreValid);
endmodule

bind intr_state_capture isc_checker #(
  .DATA_W  (DATA_W),
  .SLOT_LSB(SLOT_LSB),
  .IC_BIT  (IC_BIT)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .intrReq       (intrReq),
  .rfiReq        (rfiReq),
  .slotIdx       (slotIdx),
  .liveStatus    (liveStatus),
  .retireValid   (retireValid),
  .swWrEn        (swWrEn),
  .restoreValid  (restoreValid),
  .restoredStatus(restoredStatus),
  .redirAddr     (redirAddr),
  .savedStatus   (u_dp.savedStatus),
  .savedIp       (u_dp.savedIp),
  .lastRetired   (u_dp.lastRetired),
  .frameState    (u_dp.frameState)
);

// File: tb/tb_intr_state_capture.sv
`timescale 1ns/1ps
module tb_intr_state_capture;
  localparam int DW = 64;
  localparam int IW = 21;
  localparam int SL = 8;
  localparam int IC = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] liveStatus = '0, bundleIp = '0, retireAddr = '0;
  logic [DW-1:0] faultAddr = '0, pageAttr = '0, hashAddr = '0, swWrData = '0;
  logic [1:0] slotIdx = '0;
  logic retireValid = 0, intrReq = 0, rfiReq = 0, swWrEn = 0;
  logic [3:0] intrClass = '0;
  logic [IW-1:0] intrImm = '0;
  logic [2:0] swWrSel = '0, rdSel = '0;
  logic [DW-1:0] rdData, restoredStatus, redirAddr;
  logic restoreValid;

  always #5 clk = ~clk;

  intr_state_capture #(.DATA_W(DW), .IMM_W(IW), .SLOT_LSB(SL), .IC_BIT(IC)) dut (
    .clk(clk), .rstN(rstN), .liveStatus(liveStatus), .bundleIp(bundleIp),
    .slotIdx(slotIdx), .retireValid(retireValid), .retireAddr(retireAddr),
    .intrReq(intrReq), .intrClass(intrClass), .faultAddr(faultAddr),
    .pageAttr(pageAttr), .hashAddr(hashAddr), .intrImm(intrImm),
    .rfiReq(rfiReq), .swWrEn(swWrEn), .swWrSel(swWrSel), .swWrData(swWrData),
    .rdSel(rdSel), .rdData(rdData), .restoreValid(restoreValid),
    .restoredStatus(restoredStatus), .redirAddr(redirAddr));

  int compared = 0;
  int mismatched = 0;

  // reference state
  logic [DW-1:0] mReg [8];
  logic mRv;
  logic [DW-1:0] mRs, mRa;

  function automatic string reqOf(int sel);
    case (sel)
      0: return "R1"; 1: return "R2"; 2: return "R5"; 3: return "R5";
      4: return "R4"; 5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic cmp(string tag, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s/%s actual=%h expected=%h at %0t", tag, req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mReg[i] = '0;
    mRv = 0; mRs = '0; mRa = '0;
  endtask

  task automatic modelUpdate();
    logic [DW-1:0] nx [8];
    for (int i = 0; i < 8; i++) nx[i] = mReg[i];
    if (rfiReq && !intrReq) begin mRv = 1; mRs = mReg[0]; mRa = mReg[1]; end
    else mRv = 0;
    if (swWrEn) begin
      nx[swWrSel] = swWrData;
      if (swWrSel == 3'd1 || swWrSel == 3'd4) nx[swWrSel][3:0] = 4'h0;
    end
    if (retireValid && liveStatus[IC]) nx[4] = {retireAddr[DW-1:4], 4'h0};
    if (intrReq) begin
      nx[0] = liveStatus; nx[0][SL +: 2] = slotIdx;
      nx[1] = {bundleIp[DW-1:4], 4'h0};
      if (intrClass == 4'd1 || intrClass == 4'd2) begin nx[2] = faultAddr; nx[3] = pageAttr; end
      if (intrClass == 4'd2) nx[6] = hashAddr;
      if (intrClass == 4'd3 || intrClass == 4'd4) nx[5] = {{(DW-IW){1'b0}}, intrImm};
      nx[7][DW-1] = 1'b0;
    end
    for (int i = 0; i < 8; i++) mReg[i] = nx[i];
  endtask

  task automatic checkAll(string tag);
    cmp(tag, "R3", {{(DW-1){1'b0}}, restoreValid}, {{(DW-1){1'b0}}, mRv});
    cmp(tag, "R3", restoredStatus, mRs);
    cmp(tag, "R3", redirAddr, mRa);
    for (int i = 0; i < 8; i++) begin
      rdSel = 3'(i);
      #0.3;
      cmp(tag, reqOf(i), rdData, mReg[i]);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelUpdate();
    #1;
    checkAll(tag);
    @(negedge clk);
    intrReq = 0; rfiReq = 0; swWrEn = 0; retireValid = 0;
  endtask

  task automatic takeIntr(logic [3:0] cls, logic [1:0] slot);
    intrReq = 1; intrClass = cls; slotIdx = slot;
  endtask

  task automatic swWrite(logic [2:0] sel, logic [DW-1:0] d);
    swWrEn = 1; swWrSel = sel; swWrData = d;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    #0.5;
    checkAll("R12 reset");

    // R1 / R2: capture with slot bits pre-set in live status, unaligned IP
    liveStatus = 64'hA5A5_0000_0000_2300; bundleIp = 64'h0000_4000_1234_567F;
    takeIntr(4'd0, 2'd2); step("R1 R2 capture");
    // R5: address fault
    faultAddr = 64'hDEAD_BEEF_0000_1000; pageAttr = 64'h0000_0000_0ABC_0034;
    takeIntr(4'd1, 2'd1); step("R5 addr class");
    // R5: unrelated class leaves address regs
    faultAddr = 64'h1111; pageAttr = 64'h2222; takeIntr(4'd9, 2'd0); step("R5 other class");
    // R7: table walk
    hashAddr = 64'hFFFF_0000_CAFE_0000; faultAddr = 64'h3333;
    takeIntr(4'd2, 2'd0); step("R7 walk class");
    // R6: break and speculation check
    intrImm = 21'h1F_FFFF; takeIntr(4'd3, 2'd1); step("R6 break");
    intrImm = 21'h00_0ABC; takeIntr(4'd4, 2'd2); step("R6 spec");
    // R4: retire gating
    liveStatus = 64'h0000_0000_0000_2000; retireValid = 1; retireAddr = 64'h0000_0000_0008_0019;
    step("R4 ic=1");
    liveStatus = 64'h0; retireValid = 1; retireAddr = 64'h0000_0000_0009_0000;
    step("R4 ic=0");
    // R8: frame valid clear
    swWrite(3'd7, '1); step("R8 sw frame");
    takeIntr(4'd0, 2'd0); step("R8 clear");
    // R9: software edit then rfi
    swWrite(3'd0, 64'h0123_4567_89AB_CDEF); step("R9 sw status");
    swWrite(3'd1, 64'h0000_7777_0000_0013); step("R9 sw ip");
    rfiReq = 1; step("R9 R3 rfi");
    step("R3 idle after rfi");
    // R10: simultaneous interruption and rfi
    liveStatus = 64'h0000_0000_0000_0100; bundleIp = 64'h5550;
    takeIntr(4'd0, 2'd1); rfiReq = 1; step("R10 intr+rfi");
    // R11: hardware beats software on same register
    liveStatus = 64'hFACE_0000_0000_0000; swWrite(3'd0, 64'h1); takeIntr(4'd0, 2'd0);
    step("R11 status conflict");
    swWrite(3'd4, 64'h9999); liveStatus = 64'h2000; retireValid = 1; retireAddr = 64'h4440;
    step("R11 retire conflict");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      liveStatus  = {$urandom, $urandom};
      bundleIp    = {$urandom, $urandom};
      slotIdx     = 2'($urandom_range(0, 2));
      retireValid = ($urandom_range(0, 1) == 1);
      retireAddr  = {$urandom, $urandom};
      intrReq     = ($urandom_range(0, 7) == 0);
      intrClass   = 4'($urandom_range(0, 15));
      faultAddr   = {$urandom, $urandom};
      pageAttr    = {$urandom, $urandom};
      hashAddr    = {$urandom, $urandom};
      intrImm     = IW'($urandom);
      rfiReq      = ($urandom_range(0, 5) == 0);
      swWrEn      = ($urandom_range(0, 5) == 0);
      swWrSel     = 3'($urandom_range(0, 7));
      swWrData    = {$urandom, $urandom};
      step("R1-random R9 R10 R11");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule